// File: doc/BRIEF.md
# Bank Read-While-Busy Arbiter

This block sits in front of a banked, sectored memory and decides, in the same cycle a request arrives, whether a host read or program may go ahead while a program or erase is running. It tracks one busy bank, the kind of operation running there, whether an erase has been suspended, and the set of sectors of that bank that the erase covers.

Each request address is split into a bank number and a sector number. The last bank keeps small boot sectors in its top main-sector slot. The grant and conflict outputs are combinational from the request and the registered busy state, so a read and a write can follow each other on consecutive cycles with no idle cycle between them. Busy-start, done, suspend and resume strobes change the tracked state at the next clock edge. All state clears on a synchronous active-high reset.

Top module: `bank_rwb_arbiter`

## Requirements
- R1: With the defaults (12-bit word address, 16 banks), the bank is address bits [11:8] and a main sector is bits [7:6], which gives four 64-word sectors per bank numbered 0 to 3.
- R2: While nothing is busy, every read and every program request is granted.
- R3: While an operation is busy, a read to any other bank is granted. Once the erase is suspended, a program to any other bank is also granted.
- R4: A read to the busy bank while the operation is not suspended is refused, and `conflict` is high in that cycle.
- R5: A program request is refused, with `conflict` high, whenever an operation is busy and not suspended, whatever bank it targets.
- R6: While an erase is suspended, reads and programs inside the busy bank are granted except at sectors in the erase set. Those are refused with `conflict`.
- R7: In bank 15, the top main-sector slot (offset 192 to 255) is split into four 16-word boot sectors numbered 3 to 6 in address order. The main sectors of bank 15 remain numbered 0 to 2.
- R8: A `busy_start` with `busy_erase`=1 in the busy bank, while an unsuspended erase is running, adds that sector to the erase set. A `busy_start` while a program is busy, while suspended, or aimed at another bank is ignored.
- R9: `grant` and `conflict` answer in the same cycle as `req_valid`. They are never both high, and both are low without a request.
- R10: One cycle after `busy_done`, `busy` and `erase_suspended` are low and every request is granted again.
- R11: `susp_req` suspends only a busy erase and is ignored during a program. `resume_req` clears the suspension.
- R12: A synchronous reset clears `busy`, `busy_bank`, `erase_suspended` and the erase set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present this cycle |
| req_addr | input | ADDR_W | Word address for a request or a busy start |
| req_write | input | 1 | 1 = program request, 0 = read request |
| busy_start | input | 1 | An operation starts (or an erase sector is added) at `req_addr` |
| busy_erase | input | 1 | With `busy_start`: 1 = erase, 0 = program |
| busy_done | input | 1 | The running operation has finished |
| susp_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume the suspended erase |
| grant | output | 1 | Request may proceed |
| conflict | output | 1 | Request is refused |
| busy | output | 1 | An operation is in progress |
| busy_bank | output | BANK_W | Bank of the running operation |
| erase_suspended | output | 1 | The running erase is suspended |

## Verification
The assertions assume that `busy_start` and a request never share a cycle, and that `busy_done` is never raised together with a start or a suspend. The bench only raises strobes in cycles with `req_valid` low and raises one strobe per cycle. The assertions also assume the sector decode never leaves the range of the erase-set mask, which holds for every address under the default parameters. The bench sweeps every address with both request kinds in each busy state. That includes the refused strobes, whose effect is checked through the later sweeps.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic {OP_PROGRAM = 1'b0, OP_ERASE = 1'b1} op_kind_e;
endpackage

// File: rtl/rwb_addr_decode.sv
module rwb_addr_decode #(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 4,
  parameter int MAIN_SH = 6,
  parameter int BOOT_SH = 4,
  parameter int SEC_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_o,
  output logic [SEC_W-1:0]  sect_o
);
  localparam int OFF_W     = ADDR_W - BANK_W;
  localparam int MIDX_W    = OFF_W - MAIN_SH;
  localparam int MAIN_PER  = 1 << MIDX_W;
  localparam int BOOT_BANK = (1 << BANK_W) - 1;

  logic [MIDX_W-1:0] main_idx;

  assign bank_o   = addr[ADDR_W-1 -: BANK_W];
  assign main_idx = addr[OFF_W-1:MAIN_SH];

  generate
    if (MAIN_SH > BOOT_SH) begin : g_boot_split
      logic [MAIN_SH-BOOT_SH-1:0] boot_idx;
      logic in_boot;
      assign boot_idx = addr[MAIN_SH-1:BOOT_SH];
      assign in_boot  = (bank_o == BANK_W'(BOOT_BANK)) && (main_idx == '1);
      always_comb begin
        if (in_boot) sect_o = SEC_W'(MAIN_PER - 1) + SEC_W'(boot_idx);
        else         sect_o = SEC_W'(main_idx);
      end
    end else begin : g_uniform
      assign sect_o = SEC_W'(main_idx);
    end
  endgenerate
endmodule

// File: rtl/rwb_busy_track.sv
module rwb_busy_track
  import rwb_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int SEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_kind_e          start_kind,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [SEC_W-1:0]  start_sect,
  input  logic              done,
  input  logic              suspend,
  input  logic              resume,
  output logic              busy_q,
  output op_kind_e          kind_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              susp_q,
  output logic [(1<<SEC_W)-1:0] mask_q
);
  localparam int MASK_W = 1 << SEC_W;

  logic [MASK_W-1:0] sect_bit;
  logic              can_add;

  assign sect_bit = MASK_W'(1) << start_sect;
  assign can_add  = busy_q && (kind_q == OP_ERASE) && !susp_q &&
                    (start_kind == OP_ERASE) && (start_bank == bank_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= OP_PROGRAM;
      bank_q <= '0;
      susp_q <= 1'b0;
      mask_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (start) begin
        if (!busy_q) begin
          busy_q <= 1'b1;
          kind_q <= start_kind;
          bank_q <= start_bank;
          mask_q <= (start_kind == OP_ERASE) ? sect_bit : '0;
        end else if (can_add) begin
          mask_q <= mask_q | sect_bit;
        end
      end
      if (suspend && busy_q && kind_q == OP_ERASE) susp_q <= 1'b1;
      else if (resume)                             susp_q <= 1'b0;
    end
  end

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy_q && !susp_q));
  // R11
  susp_on_erase_chk: assert property (@(posedge clk) disable iff (rst)
    susp_q |-> (busy_q && kind_q == OP_ERASE));
  // R8
  erase_set_filled_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && kind_q == OP_ERASE) |-> (mask_q != '0));
endmodule

// File: rtl/rwb_grant_logic.sv
module rwb_grant_logic #(
  parameter int BANK_W = 4,
  parameter int SEC_W  = 3
) (
  input  logic              req,
  input  logic              is_write,
  input  logic [BANK_W-1:0] bank,
  input  logic [SEC_W-1:0]  sect,
  input  logic              busy_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic              susp_q,
  input  logic [(1<<SEC_W)-1:0] mask_q,
  output logic              grant,
  output logic              conflict
);
  logic hit_bank, in_erase, ok;

  assign hit_bank = busy_q && (bank == bank_q);
  assign in_erase = mask_q[sect];

  always_comb begin
    ok = 1'b1;
    if (busy_q) begin
      if (!susp_q) ok = is_write ? 1'b0 : !hit_bank;
      else         ok = !(hit_bank && in_erase);
    end
  end

  assign grant    = req && ok;
  assign conflict = req && !ok;

  // R9
  always_comb begin
    excl_out_chk: assert (!(grant && conflict));
  end
endmodule

// File: rtl/bank_rwb_arbiter.sv
module bank_rwb_arbiter
  import rwb_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 4,
  parameter int MAIN_SH = 6,
  parameter int BOOT_SH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              busy_start,
  input  logic              busy_erase,
  input  logic              busy_done,
  input  logic              susp_req,
  input  logic              resume_req,
  output logic              grant,
  output logic              conflict,
  output logic              busy,
  output logic [BANK_W-1:0] busy_bank,
  output logic              erase_suspended
);
  localparam int OFF_W    = ADDR_W - BANK_W;
  localparam int MAIN_PER = 1 << (OFF_W - MAIN_SH);
  localparam int BOOT_PER = 1 << (MAIN_SH - BOOT_SH);
  localparam int SLOTS    = MAIN_PER + BOOT_PER - 1;
  localparam int SEC_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int MASK_W   = 1 << SEC_W;

  logic [BANK_W-1:0] dec_bank;
  logic [SEC_W-1:0]  dec_sect;
  op_kind_e          kind_q;
  logic [MASK_W-1:0] mask_q;

  rwb_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAIN_SH(MAIN_SH),
    .BOOT_SH(BOOT_SH), .SEC_W(SEC_W)
  ) u_dec (
    .addr(req_addr), .bank_o(dec_bank), .sect_o(dec_sect)
  );

  rwb_busy_track #(.BANK_W(BANK_W), .SEC_W(SEC_W)) u_track (
    .clk(clk), .rst(rst),
    .start(busy_start),
    .start_kind(busy_erase ? OP_ERASE : OP_PROGRAM),
    .start_bank(dec_bank), .start_sect(dec_sect),
    .done(busy_done), .suspend(susp_req), .resume(resume_req),
    .busy_q(busy), .kind_q(kind_q), .bank_q(busy_bank),
    .susp_q(erase_suspended), .mask_q(mask_q)
  );

  rwb_grant_logic #(.BANK_W(BANK_W), .SEC_W(SEC_W)) u_grant (
    .req(req_valid), .is_write(req_write),
    .bank(dec_bank), .sect(dec_sect),
    .busy_q(busy), .bank_q(busy_bank), .susp_q(erase_suspended),
    .mask_q(mask_q), .grant(grant), .conflict(conflict)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!grant && !conflict));
  // R3
  other_bank_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && busy && dec_bank != busy_bank) |-> grant);
  // R5
  program_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && busy && !erase_suspended) |-> conflict);
  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |-> grant);
endmodule

// File: tb/bank_rwb_arbiter_test.sv
module bank_rwb_arbiter_test;
  localparam int CLK_NS = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst, req_valid, req_write, busy_start, busy_erase, busy_done, susp_req, resume_req;
  logic [AW-1:0] req_addr;
  logic grant, conflict, busy, erase_suspended;
  logic [3:0] busy_bank;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  bit       m_busy, m_susp;
  int       m_bank;
  bit [7:0] m_mask;

  always #(CLK_NS/2) clk = ~clk;

  bank_rwb_arbiter uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .busy_start(busy_start), .busy_erase(busy_erase),
    .busy_done(busy_done), .susp_req(susp_req), .resume_req(resume_req),
    .grant(grant), .conflict(conflict), .busy(busy), .busy_bank(busy_bank),
    .erase_suspended(erase_suspended)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sect_of(input int a);
    int bk = a / 256;
    int off = a % 256;
    if (bk == 15 && off >= 192) return 3 + (off - 192) / 16;
    return off / 64;
  endfunction

  function automatic bit exp_ok(input int a, input bit w);
    int bk = a / 256;
    if (!m_busy) return 1'b1;
    if (!m_susp) return w ? 1'b0 : (bk != m_bank);
    return !(bk == m_bank && m_mask[sect_of(a)]);
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; busy_start = 0; busy_erase = 0;
    busy_done = 0; susp_req = 0; resume_req = 0; req_addr = '0;
  endtask

  // one strobe cycle, driven after a falling edge, registered at the next rising edge
  task automatic strobe(input int kind, input int a);
    @(negedge clk);
    idle_inputs();
    req_addr = AW'(a);
    case (kind)
      0: begin busy_start = 1; busy_erase = 0; end
      1: begin busy_start = 1; busy_erase = 1; end
      2: busy_done = 1;
      3: susp_req = 1;
      default: resume_req = 1;
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_state(input string tag);
    #(CLK_NS/4);
    chk({tag, " busy"}, int'(busy), int'(m_busy));
    chk({tag, " suspended"}, int'(erase_suspended), int'(m_susp));
    if (m_busy) chk({tag, " bank"}, int'(busy_bank), m_bank);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        req_valid = 1; req_addr = AW'(a); req_write = w[0];
        #(CLK_NS/4);
        chk(tag, {int'(grant), int'(conflict)}, {int'(exp_ok(a, w[0])), int'(!exp_ok(a, w[0]))});
      end
    end
    @(negedge clk);
    req_valid = 0;
    #(CLK_NS/4);
    chk("R9 no request", int'(grant) + int'(conflict), 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_busy = 0; m_susp = 0; m_bank = 0; m_mask = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #(CLK_NS/4);
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset suspended", int'(erase_suspended), 0);
    chk("R12 reset bank", int'(busy_bank), 0);

    sweep("R2 R1 idle");

    // program in bank 3, suspend must be ignored
    strobe(0, 3*256 + 5);   m_busy = 1; m_bank = 3; check_state("R8 program start");
    strobe(3, 0);           check_state("R11 suspend during program");
    strobe(1, 3*256 + 70);  check_state("R8 start while program busy");
    sweep("R3 R4 R5 program busy");
    strobe(2, 0);           m_busy = 0; check_state("R10 done");
    sweep("R10 after done");

    // erase bank 15: boot sector 4 then main sector 0, extra start on other bank ignored
    strobe(1, 15*256 + 192 + 16); m_busy = 1; m_bank = 15; m_mask = 8'h10;
    strobe(1, 15*256 + 3);        m_mask[0] = 1;
    strobe(1, 2*256 + 10);        check_state("R8 erase set");
    sweep("R4 R5 R8 erase busy");
    strobe(3, 0);                 m_susp = 1; check_state("R11 suspend erase");
    strobe(1, 15*256 + 64);       check_state("R8 add while suspended");
    sweep("R6 R7 R3 suspended bank15");
    strobe(4, 0);                 m_susp = 0; check_state("R11 resume");
    strobe(2, 0);                 m_busy = 0; m_mask = '0; check_state("R10 done erase");

    // erase bank 5 sector 2, suspended
    strobe(1, 5*256 + 128);       m_busy = 1; m_bank = 5; m_mask = 8'h04;
    strobe(3, 0);                 m_susp = 1; check_state("R11 suspend bank5");
    sweep("R6 R1 suspended bank5");

    // reset while busy
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_busy = 0; m_susp = 0; m_mask = '0;
    check_state("R12 reset while busy");
    sweep("R12 R2 after reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule